// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block decides when a microcontroller's shared reset line is pulled low. It takes a supply-below-threshold flag from an external comparator, already synchronized. It also takes a sampled level of the open-drain reset pin and a slow timebase enable pulse. It produces one output: an enable for the pin's pull-down transistor. The block never drives the pin high. Releasing the pull-down lets the external pull-up, or another device on the line, set the level.

At power-up, and after every real supply drop, the block keeps reset asserted until the supply has stayed good for a programmable number of timebase ticks. A counter filters the supply flag, so dips no longer than a set number of clocks are ignored. Any external device may pull the pin low to request a manual reset. Only the falling edge of that request starts the timer. The pin then stays low for the longer of the internal timeout and the external hold. The block's own pull-down is never mistaken for a manual request.

A four-state machine controls the block:
- BROWNOUT: supply bad; the pin is driven low and the timer is cleared.
- HOLDOFF: supply good; the pin is driven low while timeout ticks are counted.
- WAITPIN: timeout done; the drive is released and the block waits for the pin to read high.
- RUN: normal operation.

The transitions are:
- BROWNOUT to HOLDOFF when the filtered supply is good.
- HOLDOFF to WAITPIN when the timeout completes.
- WAITPIN to RUN when the pin reads high.
- RUN to HOLDOFF on a manual falling edge.
- Any state to BROWNOUT when the filtered supply is bad.

Top module: `reset_sequencer`

## Requirements
- R1: While `rst_n` is low, and after it is released with the supply flag high, `pull_low` is 1.
- R2: After the filtered supply becomes good, `pull_low` stays 1 until TIMEOUT_TICKS ticks have been counted. It falls within two clocks after the clock edge that samples the last tick.
- R3: If `supply_low` is high for GLITCH_CLKS or fewer consecutive clock edges, `pull_low` does not rise.
- R4: If `supply_low` is high for more than GLITCH_CLKS consecutive edges, `pull_low` is 1 after edge GLITCH_CLKS+2, counting the first edge that samples the dip as edge 1. It stays 1 while the supply remains low.
- R5: Ticks that arrive while the supply is bad are not counted. A supply drop during the timeout restarts the count from zero once the supply is good again.
- R6: In RUN, a high-to-low change of `pin_level` that the block did not cause sets `pull_low` to 1 at the next clock edge.
- R7: A manual request of any length holds `pull_low` for exactly TIMEOUT_TICKS ticks. Further pin activity while the block drives the pin neither extends nor restarts the count.
- R8: If the external source still holds the pin low when the timeout ends, `pull_low` is released. The block returns to RUN only once `pin_level` reads 1, and then responds to a new manual request.
- R9: The block's own assertion and release of the pull-down never act as a manual trigger. After an internal reset ends, `pull_low` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset of the block's logic |
| supply_low | input | 1 | Synchronized comparator flag, 1 = supply below trip level |
| pin_level | input | 1 | Sampled level of the shared reset pin, 0 = low |
| tick | input | 1 | One-clock timebase enable that paces the timeout |
| pull_low | output | 1 | Pull-down enable for the open-drain reset pin, 1 = drive low |

## Verification
Assertions check four things on every cycle:
- The filter output only rises after a sampled low-supply flag.
- A filtered supply fault is followed by the pull-down at the next edge.
- The drive is released only after the timer reports completion.
- The timer is zero one edge after it is cleared, and the wait-for-pin state holds while the pin stays low.

Some behaviours can only be shown by the bench's scenarios:
- The exact dip length that separates a rejected glitch from a real brown-out.
- That a restarted timeout needs the full tick count again.
- That a long external hold sets the pulse width.
- That neither the block's own release nor a re-press during the pulse starts a new timeout.

// File: rtl/reset_sequencer_pkg.sv
package reset_sequencer_pkg;

    typedef enum logic [1:0] {
        SUP_BROWNOUT = 2'd0,
        SUP_HOLDOFF  = 2'd1,
        SUP_WAITPIN  = 2'd2,
        SUP_RUN      = 2'd3
    } sup_state_t;

endpackage

// File: rtl/supply_glitch_filter.sv
module supply_glitch_filter #(
    parameter int unsigned GLITCH_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    output logic supply_bad
);
    localparam int unsigned CW = $clog2(GLITCH_CLKS + 1) + 1;

    logic [CW-1:0] run_q;
    logic          bad_q;

    // The fault is accepted only once the low flag has been seen on more than GLITCH_CLKS edges.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
            bad_q <= 1'b0;
        end else if (supply_low) begin
            if (run_q == CW'(GLITCH_CLKS)) begin
                bad_q <= 1'b1;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
            bad_q <= 1'b0;
        end
    end

    assign supply_bad = bad_q;

    p_bad_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        supply_bad |-> $past(supply_low));

    p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= CW'(GLITCH_CLKS));

endmodule

// File: rtl/timeout_ticker.sv
module timeout_ticker #(
    parameter int unsigned TIMEOUT_TICKS = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int unsigned TW = $clog2(TIMEOUT_TICKS + 1) + 1;

    logic [TW-1:0] cnt_q;

    assign done = (cnt_q == TW'(TIMEOUT_TICKS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    p_clear_zeroes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    p_count_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TW'(TIMEOUT_TICKS));

endmodule

// File: rtl/manual_edge_detect.sv
module manual_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_level,
    input  logic driving,
    output logic manual_edge
);
    logic pin_prev_q;
    logic drive_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_prev_q   <= 1'b0;
            drive_prev_q <= 1'b1;
        end else begin
            pin_prev_q   <= pin_level;
            drive_prev_q <= driving;
        end
    end

    // A fall counts only if neither the current nor the previous cycle had our own pull-down on.
    assign manual_edge = pin_prev_q && !pin_level && !driving && !drive_prev_q;

    p_edge_after_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        manual_edge |-> $past(pin_level));

    p_edge_not_after_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        manual_edge |-> !$past(driving));

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import reset_sequencer_pkg::*;
#(
    parameter int unsigned TIMEOUT_TICKS = 200,
    parameter int unsigned GLITCH_CLKS   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_low,
    input  logic pin_level,
    input  logic tick,
    output logic pull_low
);
    sup_state_t state_q, state_d;
    logic       supply_bad;
    logic       timer_done;
    logic       timer_clear;
    logic       manual_edge;

    supply_glitch_filter #(.GLITCH_CLKS(GLITCH_CLKS)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_low (supply_low),
        .supply_bad (supply_bad)
    );

    timeout_ticker #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (timer_clear),
        .tick  (tick),
        .done  (timer_done)
    );

    manual_edge_detect u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_level   (pin_level),
        .driving     (pull_low),
        .manual_edge (manual_edge)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SUP_BROWNOUT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUP_BROWNOUT: begin
                if (!supply_bad) state_d = SUP_HOLDOFF;
            end
            SUP_HOLDOFF: begin
                if (supply_bad)      state_d = SUP_BROWNOUT;
                else if (timer_done) state_d = SUP_WAITPIN;
            end
            SUP_WAITPIN: begin
                if (supply_bad)     state_d = SUP_BROWNOUT;
                else if (pin_level) state_d = SUP_RUN;
            end
            SUP_RUN: begin
                if (supply_bad)       state_d = SUP_BROWNOUT;
                else if (manual_edge) state_d = SUP_HOLDOFF;
            end
        endcase
    end

    always_comb begin
        pull_low    = 1'b0;
        timer_clear = 1'b1;
        unique case (state_q)
            SUP_BROWNOUT: pull_low = 1'b1;
            SUP_HOLDOFF: begin
                pull_low    = 1'b1;
                timer_clear = 1'b0;
            end
            SUP_WAITPIN:  pull_low = 1'b0;
            SUP_RUN:      pull_low = 1'b0;
        endcase
    end

    p_fault_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        supply_bad |=> pull_low);

    p_release_after_timeout_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pull_low) |-> $past(timer_done));

    p_manual_asserts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_RUN && manual_edge && !supply_bad) |=> pull_low);

    p_wait_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SUP_WAITPIN && !pin_level && !supply_bad) |=> (state_q == SUP_WAITPIN));

endmodule

// File: tb/tb_reset_sequencer.sv
module tb_reset_sequencer;
    localparam int unsigned TO = 6;
    localparam int unsigned GL = 4;
    localparam int NV = 5;
    localparam int unsigned DIP_LEN [NV] = '{1, 3, 4, 5, 9};
    localparam bit          DIP_RST [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_low = 1'b1;
    logic ext_low = 1'b0;
    logic tick = 1'b0;
    logic pull_low;
    logic pin_level;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    // Open-drain pin: low if either the block or the external source pulls it.
    assign pin_level = !(pull_low || ext_low);

    reset_sequencer #(.TIMEOUT_TICKS(TO), .GLITCH_CLKS(GL)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .supply_low (supply_low),
        .pin_level  (pin_level),
        .tick       (tick),
        .pull_low   (pull_low)
    );

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic give_tick();
        tick = 1'b1;
        cyc(1);
        tick = 1'b0;
        cyc(3);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) give_tick();
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(3);
        check("R1 in reset", pull_low, 1'b1);
        rst_n = 1'b1;
        cyc(2);
        check("R1 after reset, supply low", pull_low, 1'b1);
        supply_low = 1'b0;
        cyc(3);
        ticks(TO - 1);
        check("R2 held before last tick", pull_low, 1'b1);
        give_tick();
        check("R2 released after last tick", pull_low, 1'b0);
        check("R2 pin high", pin_level, 1'b1);
        cyc(10);
        check("R9 no self trigger after release", pull_low, 1'b0);

        // Vector table of supply dips: R3 rejects short ones, R4 acts on long ones.
        for (int v = 0; v < NV; v++) begin
            bit seen;
            seen = 1'b0;
            supply_low = 1'b1;
            for (int k = 0; k < int'(DIP_LEN[v]); k++) begin
                cyc(1);
                seen |= pull_low;
            end
            supply_low = 1'b0;
            for (int k = 0; k < 4; k++) begin
                cyc(1);
                seen |= pull_low;
            end
            check(DIP_RST[v] ? "R4 long dip resets" : "R3 short dip rejected", seen, DIP_RST[v]);
            if (seen) begin
                ticks(TO);
                check("R2 recovery after dip", pull_low, 1'b0);
            end
        end

        // R4 exact latency and hold while the supply stays low
        supply_low = 1'b1;
        cyc(GL + 1);
        check("R4 not yet at edge G+1", pull_low, 1'b0);
        cyc(1);
        check("R4 asserted at edge G+2", pull_low, 1'b1);
        ticks(2);
        check("R4 held while supply low", pull_low, 1'b1);
        supply_low = 1'b0;
        cyc(2);
        ticks(TO - 1);
        check("R5 brownout ticks not counted", pull_low, 1'b1);
        give_tick();
        check("R5 release after full count", pull_low, 1'b0);

        // R5 restart of a partly counted timeout
        supply_low = 1'b1;
        cyc(GL + 3);
        supply_low = 1'b0;
        cyc(2);
        ticks(TO - 2);
        supply_low = 1'b1;
        cyc(GL + 3);
        supply_low = 1'b0;
        cyc(2);
        ticks(TO - 1);
        check("R5 count restarted", pull_low, 1'b1);
        give_tick();
        check("R5 release after restart", pull_low, 1'b0);

        // R6/R7 short manual press
        ext_low = 1'b1;
        cyc(1);
        check("R6 manual edge asserts", pull_low, 1'b1);
        ext_low = 1'b0;
        ticks(TO - 1);
        check("R7 short press stretched", pull_low, 1'b1);
        give_tick();
        check("R7 release after timeout", pull_low, 1'b0);

        // R7 re-press while driving does not extend
        ext_low = 1'b1;
        cyc(1);
        ext_low = 1'b0;
        ticks(2);
        ext_low = 1'b1;
        cyc(2);
        ext_low = 1'b0;
        ticks(TO - 3);
        check("R7 re-press pending", pull_low, 1'b1);
        give_tick();
        check("R7 re-press no extension", pull_low, 1'b0);

        // R8 long external hold
        ext_low = 1'b1;
        cyc(1);
        ticks(TO);
        check("R8 drive released after timeout", pull_low, 1'b0);
        check("R8 pin still low from external", pin_level, 1'b0);
        cyc(5);
        check("R8 no retrigger while held", pull_low, 1'b0);
        ext_low = 1'b0;
        cyc(2);
        check("R8 pin high after external release", pin_level, 1'b1);
        cyc(10);
        check("R8 stays released", pull_low, 1'b0);
        ext_low = 1'b1;
        cyc(1);
        check("R8 back in run, new press accepted", pull_low, 1'b1);
        ext_low = 1'b0;
        ticks(TO);
        check("R9 released after manual pulse", pull_low, 1'b0);
        cyc(10);
        check("R9 own release not a trigger", pull_low, 1'b0);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule